// File: doc/BRIEF.md
# Per-Bank Auto-Precharge Timer

This block sits beside the command issue stage of a DRAM controller and keeps one small timing record per bank. It watches ACTIVATE, READ and WRITE commands as they are sampled. When a READ or WRITE carries the auto-precharge flag (address bit 10 on the memory bus), the block closes that bank's row by itself. It picks the first cycle that is late enough for two limits: the end of the burst, and the row's minimum active time counted from its ACTIVATE. From that cycle on, the bank is held off for the row-precharge period.

The controller reads `bankReady` before it schedules a command to a bank. Commands to other banks go ahead while one bank runs its automatic close. A command that reaches a bank which cannot take it is dropped and reported on that bank's `violation` line. `preStart` marks, once per close, the clock in which the internal precharge counts as issued.

Top module: `apt_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `bankReady` bit is 1, and every `preStart` and `violation` bit is 0.
- R2: `cmdOp` is coded 0 = no operation, 1 = ACTIVATE, 2 = READ, 3 = WRITE. ACTIVATE opens a closed bank. A READ or WRITE sent with `cmdAutoPre` = 0 leaves the row open and the bank ready, and never produces a `preStart`. The flag applies only to the command it comes with.
- R3: A READ or WRITE that is accepted with `cmdAutoPre` = 1 clears that bank's `bankReady` bit from the next cycle on. It then produces exactly one `preStart` pulse, one cycle wide, for that bank.
- R4: Let ACTIVATE be sampled at edge a and the auto-precharge READ or WRITE at edge r. Let B = CAS_LAT + BURST_LEN/2 for a READ and B = 1 + BURST_LEN/2 + T_WR for a WRITE. Then P = max(a + T_RAS, r + B), and `preStart` is high only in the cycle that ends with edge P.
- R5: `bankReady` rises again in the cycle that ends with edge P + T_RP. At that edge the bank is closed, so an ACTIVATE sampled there is accepted.
- R6: A command sampled while its bank's `bankReady` bit is 0 has no effect on that bank, and that bank's `violation` bit is high for the next cycle.
- R7: An ACTIVATE to a bank whose row is open, or a READ or WRITE to a closed bank, is also dropped and raises `violation` for one cycle.
- R8: Banks are independent. Commands to any other bank are accepted as usual while a bank waits for, or runs, its automatic precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 2 | Command code (see R2) |
| cmdBank | input | BANK_BITS | Target bank |
| cmdAutoPre | input | 1 | Auto-precharge flag (address bit 10) |
| bankReady | output | NUM_BANKS | Per-bank "may accept a command" mask |
| preStart | output | NUM_BANKS | Internal precharge issued this cycle |
| violation | output | NUM_BANKS | Command to this bank was dropped last cycle |

## Verification
The properties assume at most one command per cycle, which the single command port already enforces. They place no other limit on the input: illegal commands are an expected input, and the block handles them through R6 and R7. The "no second launch" and "ready drops after launch" checks need T_RP greater than one and a fresh close per row. The stimulus keeps to this by letting each bank drain completely, with a ready bit back at 1, before that bank is opened again. The directed scenarios place every ACTIVATE-to-command gap on both sides of the tRAS limit, so each branch of the maximum in R4 is taken for reads and for writes.

// File: rtl/apt_pkg.sv
package apt_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ACT   = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_APWAIT,
    BK_PRECH
  } bankState_e;

  // strobes sent from control to the per-bank counters
  typedef struct packed {
    logic loadRas;
    logic loadBurst;
    logic burstWrite;
    logic loadRp;
  } bankStrobe_t;

endpackage

// File: rtl/apt_datapath.sv
module apt_datapath
  import apt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bankStrobe_t [NUM_BANKS-1:0] strobe,
  output logic [NUM_BANKS-1:0]        rasZero,
  output logic [NUM_BANKS-1:0]        burstZero,
  output logic [NUM_BANKS-1:0]        rpZero
);

  localparam int READ_SPAN  = CAS_LAT + BURST_LEN / 2;
  localparam int WRITE_SPAN = 1 + BURST_LEN / 2 + T_WR;
  localparam int SPAN_MAX   = (READ_SPAN > WRITE_SPAN) ? READ_SPAN : WRITE_SPAN;
  localparam int MAX_A      = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int MAX_ALL    = (MAX_A > SPAN_MAX) ? MAX_A : SPAN_MAX;
  localparam int CW         = $clog2(MAX_ALL + 1);

  localparam logic [CW-1:0] RAS_LOAD   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LOAD    = CW'(T_RP - 1);
  localparam logic [CW-1:0] READ_LOAD  = CW'(READ_SPAN - 1);
  localparam logic [CW-1:0] WRITE_LOAD = CW'(WRITE_SPAN - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [CW-1:0] rasLeft;
    logic [CW-1:0] burstLeft;
    logic [CW-1:0] rpLeft;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rasLeft   <= '0;
        burstLeft <= '0;
        rpLeft    <= '0;
      end else begin
        if (strobe[b].loadRas)       rasLeft <= RAS_LOAD;
        else if (rasLeft != '0)      rasLeft <= rasLeft - 1'b1;

        if (strobe[b].loadBurst)     burstLeft <= strobe[b].burstWrite ? WRITE_LOAD : READ_LOAD;
        else if (burstLeft != '0)    burstLeft <= burstLeft - 1'b1;

        if (strobe[b].loadRp)        rpLeft <= RP_LOAD;
        else if (rpLeft != '0)       rpLeft <= rpLeft - 1'b1;
      end
    end

    assign rasZero[b]   = (rasLeft == '0);
    assign burstZero[b] = (burstLeft == '0);
    assign rpZero[b]    = (rpLeft == '0);

    // a launch from control must only come once both limits have expired
    AST_LAUNCH_AFTER_LIMITS: assert property (@(posedge clk) disable iff (!rstN)
      strobe[b].loadRp |-> (rasLeft == '0 && burstLeft == '0)); // R4
  end

endmodule

// File: rtl/apt_ctrl.sv
module apt_ctrl
  import apt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  cmdOp_e                      cmdOp,
  input  logic [BANK_BITS-1:0]        cmdBank,
  input  logic                        cmdAutoPre,
  input  logic [NUM_BANKS-1:0]        rasZero,
  input  logic [NUM_BANKS-1:0]        burstZero,
  input  logic [NUM_BANKS-1:0]        rpZero,
  output bankStrobe_t [NUM_BANKS-1:0] strobe,
  output logic [NUM_BANKS-1:0]        bankReady,
  output logic [NUM_BANKS-1:0]        preStart,
  output logic [NUM_BANKS-1:0]        violation
);

  logic isRw;
  assign isRw = (cmdOp == OP_READ) || (cmdOp == OP_WRITE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    bankState_e state, stateNext;
    logic cmdHit, rdy, closed, legal, accept, reject, launch, violReg;

    assign cmdHit = cmdValid && (cmdOp != OP_NOP) && (cmdBank == BANK_BITS'(b));
    assign closed = (state == BK_IDLE) || (state == BK_PRECH && rpZero[b]);
    assign rdy    = closed || (state == BK_OPEN);
    assign legal  = rdy && (((cmdOp == OP_ACT) && closed) || (isRw && state == BK_OPEN));
    assign accept = cmdHit && legal;
    assign reject = cmdHit && !legal;
    assign launch = (state == BK_APWAIT) && rasZero[b] && burstZero[b];

    always_comb begin
      stateNext = state;
      unique case (state)
        BK_IDLE:   if (accept) stateNext = BK_OPEN;
        BK_OPEN:   if (accept && isRw && cmdAutoPre) stateNext = BK_APWAIT;
        BK_APWAIT: if (launch) stateNext = BK_PRECH;
        BK_PRECH:  if (rpZero[b]) stateNext = accept ? BK_OPEN : BK_IDLE;
        default:   stateNext = BK_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        state   <= BK_IDLE;
        violReg <= 1'b0;
      end else begin
        state   <= stateNext;
        violReg <= reject;
      end
    end

    assign strobe[b].loadRas    = accept && (cmdOp == OP_ACT);
    assign strobe[b].loadBurst  = accept && isRw;
    assign strobe[b].burstWrite = (cmdOp == OP_WRITE);
    assign strobe[b].loadRp     = launch;

    assign bankReady[b] = rdy;
    assign preStart[b]  = launch;
    assign violation[b] = violReg;

    AST_BUSY_CMD_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
      (cmdHit && !bankReady[b]) |=> violation[b]); // R6
    AST_OPEN_ACT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
      (cmdHit && cmdOp == OP_ACT && state == BK_OPEN) |=> violation[b]); // R7
    AST_SINGLE_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
      preStart[b] |=> !preStart[b]); // R3
    AST_HOLD_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
      (preStart[b] && T_RP > 1) |=> !bankReady[b]); // R5
  end

endmodule

// File: rtl/apt_top.sv
module apt_top
  import apt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 3,
  localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [BANK_BITS-1:0] cmdBank,
  input  logic                 cmdAutoPre,
  output logic [NUM_BANKS-1:0] bankReady,
  output logic [NUM_BANKS-1:0] preStart,
  output logic [NUM_BANKS-1:0] violation
);

  bankStrobe_t [NUM_BANKS-1:0] strobe;
  logic [NUM_BANKS-1:0] rasZero, burstZero, rpZero;

  apt_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .T_RP     (T_RP)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp_e'(cmdOp)),
    .cmdBank   (cmdBank),
    .cmdAutoPre(cmdAutoPre),
    .rasZero   (rasZero),
    .burstZero (burstZero),
    .rpZero    (rpZero),
    .strobe    (strobe),
    .bankReady (bankReady),
    .preStart  (preStart),
    .violation (violation)
  );

  apt_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .T_RAS    (T_RAS),
    .T_RP     (T_RP),
    .CAS_LAT  (CAS_LAT),
    .BURST_LEN(BURST_LEN),
    .T_WR     (T_WR)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rasZero  (rasZero),
    .burstZero(burstZero),
    .rpZero   (rpZero)
  );

endmodule

// File: tb/sim_apt_top.sv
module sim_apt_top;

  localparam int NB     = 4;
  localparam int T_RAS  = 8;
  localparam int T_RP   = 3;
  localparam int CL     = 3;
  localparam int BL     = 4;
  localparam int T_WR   = 3;
  localparam int B_RD   = CL + BL / 2;
  localparam int B_WR   = 1 + BL / 2 + T_WR;

  logic clk = 1'b0;
  logic rstN;
  logic cmdValid;
  logic [1:0] cmdOp;
  logic [1:0] cmdBank;
  logic cmdAutoPre;
  logic [NB-1:0] bankReady, preStart, violation;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  apt_top #(.NUM_BANKS(NB), .T_RAS(T_RAS), .T_RP(T_RP), .CAS_LAT(CL),
            .BURST_LEN(BL), .T_WR(T_WR)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdAutoPre(cmdAutoPre),
    .bankReady(bankReady), .preStart(preStart), .violation(violation)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait for the falling edge, then present a command for the next rising edge
  task automatic step(input int op, input int bank, input bit ap);
    @(negedge clk);
    cmdValid   = (op != 0);
    cmdOp      = 2'(op);
    cmdBank    = 2'(bank);
    cmdAutoPre = ap;
  endtask

  // ACT at step 0, READ/WRITE with auto-precharge at step gap
  task automatic runAp(input int bank, input int gap, input bit isWr);
    int expP = (T_RAS > gap + (isWr ? B_WR : B_RD)) ? T_RAS : gap + (isWr ? B_WR : B_RD);
    int firstPre = -1;
    int pulses = 0;
    int readyBack = -1;
    for (int s = 0; s <= expP + T_RP + 2; s++) begin
      int op = (s == 0) ? 1 : (s == gap) ? (isWr ? 3 : 2) : 0;
      step(op, bank, (s == gap));
      if (preStart[bank]) begin
        pulses++;
        if (firstPre < 0) firstPre = s;
      end
      if (s == gap + 1) chk(!bankReady[bank], "R3 ready low after ap", bankReady[bank], 0);
      if (s > gap + 1 && bankReady[bank] && readyBack < 0) readyBack = s;
    end
    chk(firstPre == expP, "R4 launch edge", firstPre, expP);
    chk(pulses == 1, "R3 single pulse", pulses, 1);
    chk(readyBack == expP + T_RP, "R5 ready return", readyBack, expP + T_RP);
  endtask

  task automatic testReset();
    chk(bankReady == '1, "R1 ready", int'(bankReady), 15);
    chk(preStart == '0, "R1 preStart", int'(preStart), 0);
    chk(violation == '0, "R1 violation", int'(violation), 0);
  endtask

  // bank0 auto-closes while bank1 runs plain reads/writes
  task automatic testConcurrent();
    int firstPre0 = -1;
    int b1Bad = 0;
    for (int s = 0; s <= 16; s++) begin
      case (s)
        0:  step(1, 0, 0);
        1:  step(2, 0, 1);
        2:  step(1, 1, 0);
        3:  step(3, 1, 0);
        4:  step(2, 1, 0);
        11: step(1, 0, 0);
        13: step(1, 1, 0);
        default: step(0, 0, 0);
      endcase
      if (preStart[0] && firstPre0 < 0) firstPre0 = s;
      if (s >= 3 && s <= 13 && (!bankReady[1] || violation[1] || preStart[1])) b1Bad++;
      if (s == 12) begin
        chk(!violation[0], "R5 act accepted at P+tRP", violation[0], 0);
        chk(bankReady[0], "R5 bank0 open and ready", bankReady[0], 1);
      end
      if (s == 14) chk(violation[1], "R2 no ap keeps row open", violation[1], 1);
    end
    chk(firstPre0 == T_RAS, "R8 bank0 launch undisturbed", firstPre0, T_RAS);
    chk(b1Bad == 0, "R8 R2 bank1 unaffected", b1Bad, 0);
  endtask

  task automatic closeBank(input int bank);
    step(2, bank, 1);
    for (int s = 0; s < T_RAS + T_RP + B_WR; s++) step(0, 0, 0);
  endtask

  // busy-bank command is dropped and flagged
  task automatic testReject();
    int firstPre = -1;
    for (int s = 0; s <= 13; s++) begin
      case (s)
        0: step(1, 2, 0);
        1: step(2, 2, 1);
        3: step(3, 2, 0);
        default: step(0, 0, 0);
      endcase
      if (preStart[2] && firstPre < 0) firstPre = s;
      if (s == 4) chk(violation[2], "R6 flag", violation[2], 1);
      if (s == 5) chk(!violation[2], "R6 one cycle", violation[2], 0);
    end
    chk(firstPre == T_RAS, "R6 rejected write ignored", firstPre, T_RAS);
  endtask

  task automatic testIllegal();
    step(2, 3, 0);
    step(3, 3, 1);
    chk(violation[3], "R7 read to closed", violation[3], 1);
    step(1, 3, 0);
    chk(violation[3], "R7 write to closed", violation[3], 1);
    chk(bankReady[3] && !preStart[3], "R7 closed bank untouched", int'(bankReady[3]), 1);
    step(1, 3, 0);
    chk(!violation[3], "R7 act to closed ok", violation[3], 0);
    step(0, 0, 0);
    chk(violation[3], "R7 act to open", violation[3], 1);
    closeBank(3);
  endtask

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'd0; cmdBank = 2'd0; cmdAutoPre = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runAp(0, 1, 1'b0);
    runAp(1, 5, 1'b0);
    runAp(2, 1, 1'b1);
    runAp(3, 4, 1'b1);
    testConcurrent();
    closeBank(0);
    closeBank(1);
    testReject();
    testIllegal();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #200000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule